// File: doc/BRIEF.md
# Interrupt Vector Table with Pending Replay

This block holds the message vector table and the pending bit array of a PCIe-style endpoint that signals interrupts as memory writes. Device logic raises one trigger line per vector. For each trigger the block either issues the vector's address/data message on a valid/ready output or, if delivery is blocked, records the event in the vector's pending bit. Delivery is blocked by the per-vector mask, by the function-wide mask, or by the global enable being clear.

Software reaches three regions through a simple register port that returns read data one cycle after the request. The regions are the table, the pending array and the control word. The region is chosen by a select input, and a byte offset addresses data inside the region. A scan pointer walks the vectors one per clock. It issues a message for any vector that is both pending and deliverable. So a trigger on an open vector, a per-vector unmask and a function-mask release all end in a message through the same path. The pending bit of a vector clears on the handshake that accepts its message.

Top module: `msix_ctrl`

## Requirements
- R1: The table has one 16-byte entry per vector. A 4-byte access at entry offsets 0, 4, 8 and 0xC reaches, in turn, address low, address high, message data and vector control. Only bit 0 of vector control, the mask, is kept. Its other bits read 0.
- R2: An 8-byte table access at entry offset 0 carries {address high, address low}. At entry offset 8 it carries {vector control, message data}, with the mask in bit 32.
- R3: The block rejects three kinds of table access: an offset with bits 1:0 not zero, an 8-byte access with offset bit 2 set, and an entry index at or beyond the vector count. A rejected read returns 0 and a rejected write changes nothing.
- R4: Pending bit n sits in qword n/64 at bit n%64, at pending offset 8*(n/64). A 4-byte read returns the low half at offset bit 2 = 0 and the high half at offset bit 2 = 1. Writes to the pending region change no bit.
- R5: The control word reads {enable[15], function mask[14], 0[13:11], vector count minus 1 [10:0]}. Only bits 15 and 14 can be written, with a 4-byte write at control offset 0. Both reset to 0.
- R6: A trigger on a vector that is unmasked, with enable set and function mask clear, produces one message within vector count + 3 cycles. The message carries that entry's address and data. The pending bit clears when ready accepts it.
- R7: A trigger while the vector mask is set, the function mask is set or enable is clear sets the pending bit and issues no message.
- R8: Clearing a vector's mask while its pending bit is set, with the function mask clear and enable set, issues its message and clears the bit.
- R9: Clearing the function mask issues exactly one message for each pending, unmasked vector. Pending vectors that are masked stay pending.
- R10: While valid is high and ready low, valid, address and data hold steady.
- R11: The mask query output, one cycle after the index is presented, reports the vector's mask bit. For an index at or beyond the vector count it reports 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 2 | Region: 0 table, 1 pending, 2 control |
| reg_off | input | OFF_W | Byte offset inside the region |
| reg_size8 | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| reg_wdata | input | 64 | Write data (4-byte data in bits 31:0) |
| reg_rdata | output | 64 | Read data, valid the cycle after reg_rd |
| reg_rvalid | output | 1 | Read data valid |
| trig | input | NUM_VEC | Per-vector event pulses |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Message accepted when high with valid |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data |
| q_idx | input | 12 | Vector index for the mask query |
| q_masked | output | 1 | Mask query result |

## Verification
The bench uses 70 vectors, so the pending array spans two qwords and has high halves that are in use. It sweeps every vector through trigger and delivery, with each expected address and data computed from the vector index. A design with a wrong entry stride or a wrong fetch index would send some other entry's message. Masking through each of the three gates must leave the pending bits set with no output. Wrong qword or bit placement shows up on readback of vectors 2, 40 and 65. The function-mask release must deliver each open pending vector exactly once, so a replay that repeats a vector or skips one is caught. The bench stalls ready to catch a message that changes while it waits, and it tries misaligned, oversized and out-of-range accesses to catch writes that leak into the table.

// File: rtl/msix_pkg.sv
package msix_pkg;
  localparam int MAX_VEC = 2048;
  localparam int QW_BITS = 64;

  typedef enum logic [1:0] {
    SEL_TABLE = 2'd0,
    SEL_PEND  = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/msix_table.sv
module msix_table #(
  parameter int NUM_VEC = 8,
  parameter int OFF_W   = 16,
  localparam int VW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [OFF_W-1:0]   off,
  input  logic               size8,
  input  logic [63:0]        wdata,
  output logic [63:0]        rdata,
  input  logic [VW-1:0]      f_idx,
  output logic [63:0]        f_addr,
  output logic [31:0]        f_data,
  output logic [NUM_VEC-1:0] mask
);
  localparam logic [OFF_W-5:0] NV = (OFF_W-4)'(NUM_VEC);

  logic [31:0] t_lo  [NUM_VEC];
  logic [31:0] t_hi  [NUM_VEC];
  logic [31:0] t_dat [NUM_VEC];

  logic [OFF_W-5:0] ent;
  logic [VW-1:0]    ei;
  logic             ok;

  assign ent = off[OFF_W-1:4];
  assign ei  = ent[VW-1:0];
  // R3: alignment, width and range filter
  assign ok  = (ent < NV) && (off[1:0] == 2'b00) && !(size8 && off[2]);

  always_ff @(posedge clk) begin
    if (wr && ok) begin
      case (off[3:2])
        2'd0: begin
          t_lo[ei] <= wdata[31:0];
          if (size8) t_hi[ei] <= wdata[63:32];
        end
        2'd1: t_hi[ei]  <= wdata[31:0];
        2'd2: t_dat[ei] <= wdata[31:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (wr && ok) begin
      if (off[3:2] == 2'd3)                 mask[ei] <= wdata[0];
      else if (off[3:2] == 2'd2 && size8)   mask[ei] <= wdata[32];
    end
  end

  always_comb begin
    rdata = '0;
    if (ok) begin
      case (off[3:2])
        2'd0: rdata = size8 ? {t_hi[ei], t_lo[ei]} : {32'd0, t_lo[ei]};
        2'd1: rdata = {32'd0, t_hi[ei]};
        2'd2: rdata = size8 ? {31'd0, mask[ei], t_dat[ei]} : {32'd0, t_dat[ei]};
        default: rdata = {63'd0, mask[ei]};
      endcase
    end
  end

  assign f_addr = {t_hi[f_idx], t_lo[f_idx]};
  assign f_data = t_dat[f_idx];
endmodule

// File: rtl/msix_pend.sv
module msix_pend #(
  parameter int NUM_VEC = 8,
  localparam int VW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_VEC-1:0] trig,
  input  logic [NUM_VEC-1:0] elig,
  input  logic               busy,
  input  logic               clr_en,
  input  logic [VW-1:0]      clr_idx,
  output logic [NUM_VEC-1:0] pend,
  output logic               hit,
  output logic [VW-1:0]      hit_idx
);
  logic [VW-1:0]      ptr;
  logic [NUM_VEC-1:0] clr_mask;

  assign clr_mask = clr_en ? (NUM_VEC'(1) << clr_idx) : '0;

  // a fresh trigger wins over a clear on the same vector
  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= (pend & ~clr_mask) | trig;
  end

  // sweep one entry per clock while the output slot is free
  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (!busy) ptr <= (ptr == VW'(NUM_VEC-1)) ? '0 : ptr + 1'b1;
  end

  assign hit     = !busy && pend[ptr] && elig[ptr];
  assign hit_idx = ptr;

  p_trig_sets_pend_r7: assert property (@(posedge clk) disable iff (rst)
    (|trig) |=> ((pend & $past(trig)) == $past(trig)));

  p_pend_only_by_trig_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((pend & ~$past(pend) & ~$past(trig)) == '0));

  p_clear_on_accept_r6: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !trig[clr_idx]) |=> !pend[$past(clr_idx)]);
endmodule

// File: rtl/msix_ctrl.sv
module msix_ctrl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 8,
  parameter int OFF_W   = 16,
  localparam int VW     = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1,
  localparam int NQW    = (NUM_VEC + QW_BITS - 1) / QW_BITS,
  localparam int QWW    = (NQW > 1) ? $clog2(NQW) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [1:0]         reg_sel,
  input  logic [OFF_W-1:0]   reg_off,
  input  logic               reg_size8,
  input  logic [63:0]        reg_wdata,
  output logic [63:0]        reg_rdata,
  output logic               reg_rvalid,
  input  logic [NUM_VEC-1:0] trig,
  output logic               msg_valid,
  input  logic               msg_ready,
  output logic [63:0]        msg_addr,
  output logic [31:0]        msg_data,
  input  logic [11:0]        q_idx,
  output logic               q_masked
);
  localparam logic [OFF_W-4:0] NQ    = (OFF_W-3)'(NQW);
  localparam logic [11:0]      NV12  = 12'(NUM_VEC);
  localparam logic [10:0]      TSIZE = 11'(NUM_VEC - 1);

  reg_sel_e            sel;
  logic                en, fmask;
  logic [63:0]         tbl_rdata, f_addr;
  logic [31:0]         f_data;
  logic [NUM_VEC-1:0]  vmask, pend, elig;
  logic                hit;
  logic [VW-1:0]       hit_idx, out_idx;
  logic [NQW*QW_BITS-1:0] pend_pad;
  logic [OFF_W-4:0]    qw;
  logic                pend_ok;
  logic [63:0]         pend_q, rd_mux;
  logic                accept;

  assign sel    = reg_sel_e'(reg_sel);
  assign accept = msg_valid && msg_ready;
  assign elig   = ~vmask & {NUM_VEC{en & ~fmask}};

  msix_table #(.NUM_VEC(NUM_VEC), .OFF_W(OFF_W)) u_table (
    .clk(clk), .rst(rst),
    .wr(reg_wr && sel == SEL_TABLE), .off(reg_off), .size8(reg_size8),
    .wdata(reg_wdata), .rdata(tbl_rdata),
    .f_idx(hit_idx), .f_addr(f_addr), .f_data(f_data), .mask(vmask)
  );

  msix_pend #(.NUM_VEC(NUM_VEC)) u_pend (
    .clk(clk), .rst(rst), .trig(trig), .elig(elig), .busy(msg_valid),
    .clr_en(accept), .clr_idx(out_idx),
    .pend(pend), .hit(hit), .hit_idx(hit_idx)
  );

  // control word: only enable and function mask are writable (R5)
  always_ff @(posedge clk) begin
    if (rst) begin
      en    <= 1'b0;
      fmask <= 1'b0;
    end else if (reg_wr && sel == SEL_CTRL && reg_off == '0 && !reg_size8) begin
      en    <= reg_wdata[15];
      fmask <= reg_wdata[14];
    end
  end

  // pending array readout (R4)
  assign pend_pad = (NQW*QW_BITS)'(pend);
  assign qw       = reg_off[OFF_W-1:3];
  assign pend_ok  = (qw < NQ) && (reg_off[1:0] == 2'b00) && !(reg_size8 && reg_off[2]);
  assign pend_q   = pend_pad[qw[QWW-1:0]*QW_BITS +: QW_BITS];

  always_comb begin
    rd_mux = '0;
    case (sel)
      SEL_TABLE: rd_mux = tbl_rdata;
      SEL_PEND:  if (pend_ok)
                   rd_mux = reg_size8 ? pend_q :
                            (reg_off[2] ? {32'd0, pend_q[63:32]} : {32'd0, pend_q[31:0]});
      SEL_CTRL:  if (reg_off == '0 && !reg_size8)
                   rd_mux = {48'd0, en, fmask, 3'd0, TSIZE};
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata  <= '0;
      reg_rvalid <= 1'b0;
    end else begin
      reg_rvalid <= reg_rd;
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  // output message slot
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid <= 1'b0;
      msg_addr  <= '0;
      msg_data  <= '0;
      out_idx   <= '0;
    end else if (hit) begin
      msg_valid <= 1'b1;
      msg_addr  <= f_addr;
      msg_data  <= f_data;
      out_idx   <= hit_idx;
    end else if (accept) begin
      msg_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) q_masked <= 1'b1;
    else     q_masked <= (q_idx >= NV12) ? 1'b1 : vmask[q_idx[VW-1:0]];
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_addr) && $stable(msg_data)));

  p_gate_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(msg_valid) |-> $past(en && !fmask));

  p_query_range_r11: assert property (@(posedge clk) disable iff (rst)
    (q_idx >= NV12) |=> q_masked);

  p_ctrl_size_r5: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && sel == SEL_CTRL && reg_off == '0 && !reg_size8) |=> (reg_rdata[10:0] == TSIZE));
endmodule

// File: tb/msix_ctrl_tb.sv
module msix_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 70;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 0, reg_rd = 0, reg_size8 = 0;
  logic [1:0]  reg_sel = 0;
  logic [15:0] reg_off = 0;
  logic [63:0] reg_wdata = 0;
  logic [63:0] reg_rdata;
  logic        reg_rvalid;
  logic [NV-1:0] trig = '0;
  logic        msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic [11:0] q_idx = 0;
  logic        q_masked;

  int checks = 0, fails = 0, msg_cnt = 0;
  int seen [NV];
  logic [63:0] last_addr;
  logic [31:0] last_data;
  logic [63:0] rv;

  always #(CLK_PERIOD/2) clk = ~clk;

  msix_ctrl #(.NUM_VEC(NV), .OFF_W(16)) u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_off(reg_off), .reg_size8(reg_size8), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid), .trig(trig),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_addr(msg_addr),
    .msg_data(msg_data), .q_idx(q_idx), .q_masked(q_masked)
  );

  function automatic logic [63:0] exp_addr(int v);
    return {32'h100 + 32'(v), 32'hA000_0000 + 32'(v*16)};
  endfunction
  function automatic logic [31:0] exp_data(int v);
    return 32'hD000_0000 + 32'(v);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // accepted messages, sampled just after the negative edge drives settle
  always @(negedge clk) begin
    #1;
    if (!rst && msg_valid && msg_ready) begin
      msg_cnt++;
      last_addr = msg_addr;
      last_data = msg_data;
      if (msg_data[15:0] < NV) seen[msg_data[15:0]]++;
    end
  end

  task automatic wr(logic [1:0] s, int off, logic s8, logic [63:0] d);
    @(negedge clk);
    reg_sel = s; reg_off = 16'(off); reg_size8 = s8; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] s, int off, logic s8, output logic [63:0] d);
    @(negedge clk);
    reg_sel = s; reg_off = 16'(off); reg_size8 = s8; reg_rd = 1;
    @(negedge clk);
    reg_rd = 0;
    d = reg_rdata;
  endtask

  task automatic pulse(int v);
    @(negedge clk);
    trig = '0; trig[v] = 1'b1;
    @(negedge clk);
    trig = '0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_cnt(int target);
    for (int i = 0; i < 400 && msg_cnt < target; i++) @(negedge clk);
    idle(1);
  endtask

  task automatic clr_seen();
    for (int i = 0; i < NV; i++) seen[i] = 0;
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks-fails, checks);
    $finish;
  end

  initial begin
    int base;
    clr_seen();
    repeat (3) @(negedge clk);
    rst = 0;
    // reset state (R5)
    check("R6 reset valid", {63'd0, msg_valid}, 64'd0);
    rd(2, 0, 0, rv); check("R5 reset ctrl", rv, 64'h45);
    rd(1, 0, 1, rv); check("R4 reset pend", rv, 64'd0);

    // R1: fill table through 4-byte writes
    for (int v = 0; v < NV; v++) begin
      wr(0, v*16 + 0, 0, {32'd0, exp_addr(v)[31:0]});
      wr(0, v*16 + 4, 0, {32'd0, exp_addr(v)[63:32]});
      wr(0, v*16 + 8, 0, {32'd0, exp_data(v)});
    end
    rd(0, 17*16+4, 0, rv); check("R1 addr hi", rv, {32'd0, exp_addr(17)[63:32]});
    rd(0, 69*16+8, 0, rv); check("R1 data", rv, {32'd0, exp_data(69)});
    wr(0, 3*16+12, 0, 64'hFFFF_FFFF);
    rd(0, 3*16+12, 0, rv); check("R1 vctl bit0 only", rv, 64'd1);
    wr(0, 3*16+12, 0, 64'd0);

    // R2: 8-byte accesses
    wr(0, 5*16, 1, 64'h1234_5678_9ABC_DEF0);
    rd(0, 5*16+4, 0, rv); check("R2 8B write hi", rv, 64'h1234_5678);
    wr(0, 5*16, 1, exp_addr(5));
    rd(0, 5*16, 1, rv); check("R2 8B read addr", rv, exp_addr(5));
    rd(0, 5*16+8, 1, rv); check("R2 8B read vctl:data", rv, {32'd0, exp_data(5)});

    // R3: rejected accesses
    rd(0, 5*16+2, 0, rv); check("R3 misaligned read", rv, 64'd0);
    wr(0, 5*16+1, 0, 64'h0);
    rd(0, 5*16, 0, rv); check("R3 misaligned write ignored", rv, {32'd0, exp_addr(5)[31:0]});
    rd(0, 5*16+4, 1, rv); check("R3 8B at 4 read", rv, 64'd0);
    wr(0, 5*16+12, 1, 64'h1_0000_0001);
    rd(0, 5*16+12, 0, rv); check("R3 8B at C write ignored", rv, 64'd0);
    rd(0, NV*16, 0, rv); check("R3 out of range read", rv, 64'd0);

    // R5: only enable/function mask writable
    wr(2, 0, 0, 64'hFFFF);
    rd(2, 0, 0, rv); check("R5 ctrl write all", rv, 64'hC045);
    wr(2, 0, 0, 64'h8000);
    rd(2, 0, 0, rv); check("R5 ctrl enable", rv, 64'h8045);

    // R6: sweep every vector
    for (int v = 0; v < NV; v++) begin
      base = msg_cnt;
      pulse(v);
      wait_cnt(base + 1);
      check("R6 count", 64'(msg_cnt), 64'(base + 1));
      check("R6 addr", last_addr, exp_addr(v));
      check("R6 data", {32'd0, last_data}, {32'd0, exp_data(v)});
    end
    rd(1, 0, 1, rv); check("R6 pend cleared", rv, 64'd0);

    // R10: stall the output
    @(negedge clk); msg_ready = 0;
    pulse(9);
    for (int i = 0; i < 100 && !msg_valid; i++) @(negedge clk);
    rv = msg_addr;
    idle(5);
    check("R10 valid held", {63'd0, msg_valid}, 64'd1);
    check("R10 addr held", msg_addr, rv);
    check("R10 data held", {32'd0, msg_data}, {32'd0, exp_data(9)});
    rd(1, 0, 0, rv); check("R6 pend set while undelivered", rv, 64'h200);
    base = msg_cnt;
    @(negedge clk); msg_ready = 1;
    wait_cnt(base + 1);
    rd(1, 0, 0, rv); check("R6 pend cleared on accept", rv, 64'd0);

    // R7 + R4: per-vector mask
    wr(0, 2*16+12, 0, 64'd1);
    wr(0, 40*16+12, 0, 64'd1);
    wr(0, 65*16+12, 0, 64'd1);
    base = msg_cnt;
    pulse(2); pulse(40); pulse(65);
    idle(160);
    check("R7 no msg when masked", 64'(msg_cnt), 64'(base));
    rd(1, 0, 1, rv); check("R4 qword0 8B", rv, (64'd1 << 2) | (64'd1 << 40));
    rd(1, 4, 0, rv); check("R4 qword0 high half", rv, 64'h100);
    rd(1, 8, 0, rv); check("R4 qword1 low half", rv, 64'h2);
    wr(1, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(1, 8, 0, 64'd0);
    rd(1, 0, 1, rv); check("R4 pend write ignored q0", rv, (64'd1 << 2) | (64'd1 << 40));
    rd(1, 8, 1, rv); check("R4 pend write ignored q1", rv, 64'h2);

    // R8: unmask replays
    base = msg_cnt;
    wr(0, 2*16+12, 0, 64'd0);
    wait_cnt(base + 1);
    check("R8 replay data", {32'd0, last_data}, {32'd0, exp_data(2)});
    rd(1, 0, 0, rv); check("R8 pend cleared", rv, 64'd0);

    // R9: function mask sweep
    wr(2, 0, 0, 64'hC000);
    clr_seen();
    base = msg_cnt;
    pulse(0); pulse(1); pulse(7);
    idle(160);
    check("R7 no msg under fmask", 64'(msg_cnt), 64'(base));
    wr(2, 0, 0, 64'h8000);
    idle(250);
    check("R9 count", 64'(msg_cnt), 64'(base + 3));
    check("R9 v0 once", 64'(seen[0]), 64'd1);
    check("R9 v1 once", 64'(seen[1]), 64'd1);
    check("R9 v7 once", 64'(seen[7]), 64'd1);
    rd(1, 0, 1, rv); check("R9 masked stay pending", rv, 64'd1 << 40);
    rd(1, 8, 1, rv); check("R9 masked stay pending q1", rv, 64'h2);
    base = msg_cnt;
    wr(0, 40*16+8, 1, {32'd0, exp_data(40)});
    wr(0, 65*16+12, 0, 64'd0);
    wait_cnt(base + 2);
    check("R8 two replays", 64'(msg_cnt), 64'(base + 2));

    // R7: enable clear
    wr(2, 0, 0, 64'h0);
    base = msg_cnt;
    pulse(4);
    idle(160);
    check("R7 no msg when disabled", 64'(msg_cnt), 64'(base));
    rd(1, 0, 0, rv); check("R7 pend when disabled", rv, 64'h10);
    wr(2, 0, 0, 64'h8000);
    wait_cnt(base + 1);
    check("R6 delivered after enable", {32'd0, last_data}, {32'd0, exp_data(4)});

    // R11: mask query
    wr(0, 3*16+12, 0, 64'd1);
    @(negedge clk); q_idx = 3;
    @(negedge clk); check("R11 masked vector", {63'd0, q_masked}, 64'd1);
    q_idx = 4;
    @(negedge clk); check("R11 open vector", {63'd0, q_masked}, 64'd0);
    q_idx = 12'(NV);
    @(negedge clk); check("R11 index at size", {63'd0, q_masked}, 64'd1);
    q_idx = 12'd2047;
    @(negedge clk); check("R11 index far", {63'd0, q_masked}, 64'd1);

    $display("%0d/%0d checks passed", checks-fails, checks);
    $finish;
  end
endmodule